// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave may still be holding after the main master was reset in the middle of a transfer. It runs only while the main master engine is disabled. When it receives a start pulse, it takes control of both open-drain lines and leaves SDA released. It then drives a fixed train of full SCL clock pulses. A stuck slave can use these pulses to shift out whatever it was sending and let go of SDA. The block finishes with a STOP condition and gives the lines back.

The length of each SCL phase is set in system clocks by a half-period input. The value is captured when the start is accepted. If a slave holds SCL low, the block waits for it. The main controller raises `start_i` once, watches `busy_o`, and re-initializes its own engine after `done_o`. Outputs `scl_oe_o` and `sda_oe_o` are pull-low enables, so a value of 1 drives the line low.

Top module: `i2c_bus_recovery`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o` and `done_o` are all 0.
- R2: A start pulse sampled while idle with `eng_en_i` = 0 is accepted. From the next cycle, `busy_o` = 1 and SCL is pulled low.
- R3: A start pulse sampled while `eng_en_i` = 1 is ignored. `busy_o` stays 0 and both lines stay released.
- R4: The sequence emits exactly PULSES (default 9) SCL pulses. Each pulse is H cycles with SCL pulled low, then H cycles with SCL released. SDA stays released throughout the train.
- R5: H is the value of `half_per_i` captured when the start is accepted, with a value of 0 treated as 1. Changes to `half_per_i` during a run have no effect.
- R6: During an SCL-released phase, the phase timer advances only in cycles where `scl_i` reads high. A slave holding SCL low for S cycles therefore lengthens that phase to H+S.
- R7: After the last pulse, the STOP condition runs in three steps, each timed separately. First, SDA and SCL are both pulled low for H cycles. Second, SCL is released while SDA is held low for H cycles, with stretching as in R6. Third, both lines are released for H cycles, counting only cycles where `sda_i` reads high.
- R8: `done_o` is high for exactly one cycle after the STOP. `busy_o` is high from acceptance through that cycle and low in the cycle after it.
- R9: A start pulse while busy is ignored, and the timing of the run in progress does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a recovery run |
| eng_en_i | input | 1 | High while the main master engine is enabled; blocks starts |
| half_per_i | input | HALF_W | SCL half-period in system clocks (0 acts as 1) |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Recovery run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The start edge that accepts a request defines time zero. `busy_o` and the SCL pull-low appear at the next falling-edge sample. Each later change of the output tuple falls on a multiple of H counted from zero, shifted by S for every stretched phase before it. In the STOP sequence, the SDA pull-low is due at 9(2H+S), SCL release at 9(2H+S)+H, SDA release at 9(2H+S)+2H+S, `done_o` one H later, and busy drop one cycle after that. A monitor timestamps every change of {busy, done, scl_oe, sda_oe} at falling edges and compares each one against a queue that the driver filled from these formulas. Any event that arrives early, late, or was never predicted fails.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOW     = 3'd1,
    ST_HIGH    = 3'd2,
    ST_STP_LOW = 3'd3,
    ST_STP_SCL = 3'd4,
    ST_STP_SDA = 3'd5,
    ST_FIN     = 3'd6
  } rec_state_t;

  // Half-period actually used: zero is promoted to one cycle.
  function automatic int unsigned eff_half(input int unsigned hp);
    return (hp == 0) ? 1 : hp;
  endfunction

  // States in which the sequencer pulls SCL low.
  function automatic logic pulls_scl(input rec_state_t s);
    return (s == ST_LOW) || (s == ST_STP_LOW);
  endfunction

  // States in which the sequencer pulls SDA low.
  function automatic logic pulls_sda(input rec_state_t s);
    return (s == ST_STP_LOW) || (s == ST_STP_SCL);
  endfunction

  // Whether the phase timer may advance in a state, given the line levels.
  function automatic logic timer_runs(input rec_state_t s, input logic scl, input logic sda);
    case (s)
      ST_LOW, ST_STP_LOW:  return 1'b1;
      ST_HIGH, ST_STP_SCL: return scl;
      ST_STP_SDA:          return sda;
      default:             return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2crec_timer.sv
module i2crec_timer #(
  parameter int HALF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [HALF_W-1:0] limit,
  output logic              phase_end
);

  logic [HALF_W-1:0] cnt;

  assign phase_end = run && (cnt == (limit - HALF_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || phase_end) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + HALF_W'(1);
    end
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt < limit));

endmodule

// File: rtl/i2crec_pcount.sv
module i2crec_pcount #(
  parameter int PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last,
  output logic full
);

  localparam int CNT_W = $clog2(PULSES + 1);

  logic [CNT_W-1:0] cnt;

  assign last = (cnt == CNT_W'(PULSES - 1));
  assign full = (cnt == CNT_W'(PULSES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R4
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PULSES));

  // R4
  no_inc_past_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !inc);

endmodule

// File: rtl/i2crec_fsm.sv
module i2crec_fsm
  import i2crec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic eng_en_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic phase_end,
  input  logic last_pulse,
  input  logic pulses_full,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic idle_o,
  output logic accept_o,
  output logic run_o,
  output logic pulse_inc_o
);

  rec_state_t state, state_nx;

  assign idle_o      = (state == ST_IDLE);
  assign accept_o    = idle_o && start_i && !eng_en_i;
  assign run_o       = timer_runs(state, scl_i, sda_i);
  assign pulse_inc_o = (state == ST_HIGH) && phase_end;
  assign scl_oe_o    = pulls_scl(state);
  assign sda_oe_o    = pulls_sda(state);
  assign busy_o      = !idle_o;
  assign done_o      = (state == ST_FIN);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (accept_o)  state_nx = ST_LOW;
      ST_LOW:     if (phase_end) state_nx = ST_HIGH;
      ST_HIGH:    if (phase_end) state_nx = last_pulse ? ST_STP_LOW : ST_LOW;
      ST_STP_LOW: if (phase_end) state_nx = ST_STP_SCL;
      ST_STP_SCL: if (phase_end) state_nx = ST_STP_SDA;
      ST_STP_SDA: if (phase_end) state_nx = ST_FIN;
      ST_FIN:                    state_nx = ST_IDLE;
      default:                   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R2
  start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && start_i && !eng_en_i) |=> (busy_o && scl_oe_o));

  // R3
  engine_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && start_i && eng_en_i) |=> !busy_o);

  // R6
  scl_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIGH && !scl_i) |=> (state == ST_HIGH));

  // R7
  sda_only_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> pulses_full);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

endmodule

// File: rtl/i2c_bus_recovery.sv
module i2c_bus_recovery
  import i2crec_pkg::*;
#(
  parameter int HALF_W = 12,
  parameter int PULSES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              eng_en_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [HALF_W-1:0] hp_q;
  logic idle, accept, run, phase_end, pulse_inc, last_pulse, pulses_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hp_q <= HALF_W'(1);
    else if (accept) hp_q <= HALF_W'(eff_half(32'(half_per_i)));
  end

  i2crec_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .eng_en_i    (eng_en_i),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .phase_end   (phase_end),
    .last_pulse  (last_pulse),
    .pulses_full (pulses_full),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .idle_o      (idle),
    .accept_o    (accept),
    .run_o       (run),
    .pulse_inc_o (pulse_inc)
  );

  i2crec_timer #(.HALF_W(HALF_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (idle),
    .run       (run),
    .limit     (hp_q),
    .phase_end (phase_end)
  );

  i2crec_pcount #(.PULSES(PULSES)) u_pcount (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idle),
    .inc   (pulse_inc),
    .last  (last_pulse),
    .full  (pulses_full)
  );

  // R5
  hp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(hp_q));

  // R5
  hp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (hp_q != '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o && !done_o));

endmodule

// File: tb/tb_i2c_bus_recovery.sv
module tb_i2c_bus_recovery;

  localparam int HW = 12;
  localparam int NP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic eng_en_i = 1'b0;
  logic [HW-1:0] half_per_i = '0;
  logic scl_i, sda_i, scl_oe_o, sda_oe_o, busy_o, done_o;
  logic hold = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_i = !(scl_oe_o || hold);
  assign sda_i = !sda_oe_o;

  i2c_bus_recovery #(.HALF_W(HW), .PULSES(NP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .eng_en_i(eng_en_i),
    .half_per_i(half_per_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct { logic [3:0] tup; int t; string tag; } ev_t;
  ev_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int stretch = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_ev(input logic [3:0] tup, input int t, input string tag);
    ev_t e;
    e.tup = tup; e.t = t; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Slave model: holds SCL low for 'stretch' clock edges each time it is released.
  int rem = 0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      hold = 1'b0; rem = 0;
    end else if (scl_oe_o == 1'b0 && prev_oe == 1'b1 && stretch > 0) begin
      hold = 1'b1; rem = stretch;
    end else if (hold) begin
      rem--;
      if (rem == 0) hold = 1'b0;
    end
    prev_oe = scl_oe_o;
  end

  // Monitor: timestamps every change of {busy, done, scl_oe, sda_oe}.
  logic [3:0] prev_tup = 4'b0000;
  int tcur = 0;
  always @(negedge clk) begin
    logic [3:0] cur;
    ev_t e;
    if (rst_n) begin
      cur = {busy_o, done_o, scl_oe_o, sda_oe_o};
      if (busy_o && !prev_tup[3]) tcur = 0;
      else tcur++;
      if (cur != prev_tup) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R9", "unexpected output change tuple", int'(cur), int'(prev_tup));
        end else begin
          e = exp_q.pop_front();
          check(cur == e.tup, e.tag, "event tuple", int'(cur), int'(e.tup));
          check(tcur == e.t, e.tag, "event time", tcur, e.t);
        end
      end
      prev_tup = cur;
    end else begin
      prev_tup = 4'b0000;
    end
  end

  // Driver: predicts the whole run, then requests it.
  task automatic run_seq(input int hp_drive, input int h, input int s, input string tag_sh, input bit poke);
    int p, b, guard;
    p = 2 * h + s;
    b = NP * p;
    stretch = s;
    push_ev(4'b1010, 0, "R2");
    for (int i = 0; i < NP; i++) begin
      if (i > 0) push_ev(4'b1010, i * p, tag_sh);
      push_ev(4'b1000, i * p + h, (s > 0) ? "R6" : tag_sh);
    end
    push_ev(4'b1011, b, "R7");
    push_ev(4'b1001, b + h, "R7");
    push_ev(4'b1000, b + 2 * h + s, "R7");
    push_ev(4'b1100, b + 3 * h + s, "R8");
    push_ev(4'b0000, b + 3 * h + s + 1, "R8");
    @(negedge clk);
    half_per_i = HW'(hp_drive);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1;               // R9: ignored while busy
      half_per_i = HW'(hp_drive + 5); // R5: ignored mid-run
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while ((busy_o || exp_q.size() != 0) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 5000, "R8", "run completion", guard, 5000);
    check(exp_q.size() == 0, "R8", "events outstanding", exp_q.size(), 0);
    exp_q.delete();
    stretch = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scl_oe_o == 1'b0, "R1", "scl_oe in reset", int'(scl_oe_o), 0);
    check(sda_oe_o == 1'b0, "R1", "sda_oe in reset", int'(sda_oe_o), 0);
    check(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_seq(3, 3, 0, "R4", 1'b0);  // R4, R7, R8 nominal
    run_seq(1, 1, 0, "R4", 1'b0);  // R4 minimum half-period
    run_seq(0, 1, 0, "R5", 1'b0);  // R5 zero acts as one
    run_seq(4, 4, 2, "R4", 1'b0);  // R6 slave stretches every release
    run_seq(2, 2, 0, "R9", 1'b1);  // R9 and R5 mid-run disturbance

    // R3: start blocked while the main engine is enabled
    eng_en_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R3", "busy with engine enabled", int'(busy_o), 0);
    check(scl_oe_o == 1'b0, "R3", "scl_oe with engine enabled", int'(scl_oe_o), 0);
    eng_en_i = 1'b0;
    repeat (2) @(negedge clk);

    run_seq(5, 5, 0, "R4", 1'b0);  // R2 start works again after block

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule